// File: doc/BRIEF.md
# Reset Hold Timer

This block keeps a processor core in reset after any reset event until a stabilisation delay has run out. It is clocked by a free-running slow tick (an on-chip RC tick, separate from the main clock), so it keeps counting while the main clock is stopped. Four events start or restart the delay:

- a power-on pulse;
- an external clear pin;
- a watchdog time-out that wakes the core from sleep;
- a pin-change wake event.

The delay length depends on two things. The first is a 3-bit oscillator-mode code. The second is whether a power-on delay has already completed. With RC-type or external-clock modes, only the first delay after power-on is long; every later reset gets a short delay. With crystal or resonator modes, every reset gets the long delay, because the oscillator must restart each time. Both delays are parameters given in ticks, so simulation can use short values while silicon uses the real ones (nominally 18 ms and 10 µs).

The core-reset output is a register. It rises on the tick after any event is seen. It falls on the tick where the count reaches the selected limit. It cannot glitch.

Top module: `rst_hold_timer`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is high on the following tick, and the first-done state is cleared, so the next delay is the long one in every mode.
- R2: After the last tick on which an event is high, `core_rst` stays high for exactly the selected number of ticks (counting the tick that saw the event), then goes low.
- R3: In modes 3 (external clock), 4 (internal RC) and 5 (external RC), a reset after a completed power-on delay gets the short delay of `SHORT_TICKS`.
- R4: In modes 0 (LP crystal), 1 (XT crystal) and 2 (HS crystal), and in the reserved codes 6 and 7, every reset gets the long delay of `LONG_TICKS`.
- R5: While `ext_clr` is held high, `core_rst` stays high and the count stays at zero. Counting starts only after `ext_clr` is released.
- R6: A one-tick `wdt_wake` pulse starts the delay, with the same length rule as any other non-power-on reset.
- R7: A one-tick `pinchg_wake` pulse starts the delay, with the same length rule.
- R8: An event that arrives while a delay is running restarts the full delay from zero. No partial count is kept.
- R9: The first-done state is set only when a delay that followed power-on completes, and only a new power-on clears it. A reset that interrupts the power-on delay therefore still gets the long delay.
- R10: Once released, `core_rst` stays low until an event is seen, and it changes only on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running slow tick clock |
| por_pulse | input | 1 | Power-on pulse, active high; it also serves as the synchronous reset |
| ext_clr | input | 1 | External clear pin, active high, level sensitive |
| wdt_wake | input | 1 | Watchdog time-out wake event, one tick wide |
| pinchg_wake | input | 1 | Pin-change wake event, one tick wide |
| osc_mode | input | 3 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 EC, 4 INTRC, 5 EXTRC, 6-7 reserved (long delay) |
| core_rst | output | 1 | Registered core reset, active high |

## Verification
The hold length is measured in ticks for each event source (power-on, clear pin, watchdog wake, pin-change wake) across every mode code. This separates the short-delay path from the long-delay path, and it also separates the two states of the first-done flag. Events are placed in the middle of a running delay, and the clear pin is held for a long time, to tell a true restart from a count that carries on. A power-on followed by an interrupted delay shows whether the flag is set too early. A long random run with rare events and occasional mode changes is compared tick by tick against a bench model, to catch timing slips of one tick.

// File: rtl/rht_pkg.sv
package rht_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] OSC_LP    = 3'd0;
  localparam logic [MODE_W-1:0] OSC_XT    = 3'd1;
  localparam logic [MODE_W-1:0] OSC_HS    = 3'd2;
  localparam logic [MODE_W-1:0] OSC_EC    = 3'd3;
  localparam logic [MODE_W-1:0] OSC_INTRC = 3'd4;
  localparam logic [MODE_W-1:0] OSC_EXTRC = 3'd5;

  // Modes whose clock needs no restart time may use the short delay after power-on.
  function automatic logic short_ok(input logic [MODE_W-1:0] m);
    return (m == OSC_EC) || (m == OSC_INTRC) || (m == OSC_EXTRC);
  endfunction
endpackage

// File: rtl/rht_delay_select.sv
module rht_delay_select #(
  parameter int LONG_TICKS  = 40,
  parameter int SHORT_TICKS = 3,
  parameter int CW          = 6
) (
  input  logic [rht_pkg::MODE_W-1:0] mode_i,
  input  logic                       first_done_i,
  output logic [CW-1:0]              limit_o
);
  import rht_pkg::*;

  always_comb begin
    limit_o = (short_ok(mode_i) && first_done_i) ? CW'(SHORT_TICKS) : CW'(LONG_TICKS);
  end

  always_comb begin
    if (mode_i inside {OSC_LP, OSC_XT, OSC_HS, 3'd6, 3'd7})
      assert_crystal_long_R4: assert (limit_o == CW'(LONG_TICKS));
    if (!first_done_i)
      assert_first_long_R9: assert (limit_o == CW'(LONG_TICKS));
  end
endmodule

// File: rtl/rht_hold_counter.sv
module rht_hold_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart_i,
  input  logic [CW-1:0] limit_i,
  output logic          hold_o,
  output logic          release_o
);
  logic [CW-1:0] cnt_q;
  logic          hold_q;
  logic          at_end;

  // >= keeps the counter safe if the limit shrinks mid-count
  assign at_end    = (cnt_q >= (limit_i - CW'(1)));
  assign release_o = hold_q && !restart_i && at_end;
  assign hold_o    = hold_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (hold_q) begin
      if (at_end) begin
        cnt_q  <= '0;
        hold_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (hold_q && cnt_q == '0));
  assert_release_at_limit_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !restart_i && cnt_q == limit_i - CW'(1)) |=> !hold_q);
  assert_stay_released_R10: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !restart_i) |=> !hold_q);
  assert_counting_advances_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !restart_i && !at_end) |=> (hold_q && cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int LONG_TICKS  = 40,
  parameter int SHORT_TICKS = 3
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       ext_clr,
  input  logic       wdt_wake,
  input  logic       pinchg_wake,
  input  logic [2:0] osc_mode,
  output logic       core_rst
);
  localparam int CW = $clog2(LONG_TICKS + 1);

  logic          first_done_q;
  logic          restart;
  logic          release_evt;
  logic [CW-1:0] limit;

  assign restart = ext_clr || wdt_wake || pinchg_wake;

  rht_delay_select #(
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS),
    .CW         (CW)
  ) sel_i (
    .mode_i      (osc_mode),
    .first_done_i(first_done_q),
    .limit_o     (limit)
  );

  rht_hold_counter #(
    .CW(CW)
  ) cnt_i (
    .clk      (clk),
    .rst      (por_pulse),
    .restart_i(restart),
    .limit_i  (limit),
    .hold_o   (core_rst),
    .release_o(release_evt)
  );

  always_ff @(posedge clk) begin
    if (por_pulse)
      first_done_q <= 1'b0;
    else if (release_evt)
      first_done_q <= 1'b1;
  end

  assert_por_holds_R1: assert property (@(posedge clk)
    por_pulse |=> (core_rst && !first_done_q));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (por_pulse)
    first_done_q |=> first_done_q);
  assert_wdt_restarts_R6: assert property (@(posedge clk) disable iff (por_pulse)
    wdt_wake |=> core_rst);
  assert_pin_restarts_R7: assert property (@(posedge clk) disable iff (por_pulse)
    pinchg_wake |=> core_rst);
  assert_flag_on_release_R9: assert property (@(posedge clk) disable iff (por_pulse)
    $rose(first_done_q) |-> $fell(core_rst));
endmodule

// File: tb/rst_hold_timer_tb_top.sv
module rst_hold_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LONG_T     = 12;
  localparam int SHORT_T    = 3;

  logic       clk = 1'b0;
  logic       por_pulse = 1'b1;
  logic       ext_clr = 1'b0;
  logic       wdt_wake = 1'b0;
  logic       pinchg_wake = 1'b0;
  logic [2:0] osc_mode = 3'd4;
  logic       core_rst;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench reference state
  bit m_hold = 1;
  int m_cnt = 0;
  bit m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_hold_timer #(.LONG_TICKS(LONG_T), .SHORT_TICKS(SHORT_T)) dut_i (
    .clk(clk), .por_pulse(por_pulse), .ext_clr(ext_clr), .wdt_wake(wdt_wake),
    .pinchg_wake(pinchg_wake), .osc_mode(osc_mode), .core_rst(core_rst));

  function automatic bit short_mode(input logic [2:0] m);
    return (m == 3'd3) || (m == 3'd4) || (m == 3'd5);
  endfunction

  function automatic int exp_len(input logic [2:0] m, input bit done);
    return (short_mode(m) && done) ? SHORT_T : LONG_T;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive inputs for one edge, advance the model, sample at the next falling edge.
  task automatic step(input bit p, input bit c, input bit w, input bit pc,
                      input logic [2:0] m, input string tag);
    int lim;
    por_pulse = p; ext_clr = c; wdt_wake = w; pinchg_wake = pc; osc_mode = m;
    if (p) m_done = 0;
    if (p || c || w || pc) begin
      m_hold = 1; m_cnt = 0;
    end else if (m_hold) begin
      lim = exp_len(m, m_done);
      if (m_cnt + 1 >= lim) begin
        m_hold = 0; m_cnt = 0; m_done = 1;
      end else m_cnt++;
    end
    @(negedge clk);
    check(core_rst == m_hold, tag, int'(core_rst), int'(m_hold));
  endtask

  task automatic idle(input int n, input logic [2:0] m, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, m, tag);
  endtask

  // kind: 0 por, 1 clear, 2 watchdog, 3 pin change
  task automatic measure(input int kind, input logic [2:0] m, input int exp, input string tag);
    int n;
    step(kind == 0, kind == 1, kind == 2, kind == 3, m, tag);
    n = core_rst ? 1 : 0;
    while (core_rst && n < 100) begin
      step(0, 0, 0, 0, m, tag);
      if (core_rst) n++;
    end
    check(n == exp, {tag, " hold length"}, n, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [2:0] rmode;
    seed = 32'h5eed;
    void'($urandom(seed));
    @(negedge clk);
    step(1, 0, 0, 0, 3'd4, "R1 reset state");
    step(1, 0, 0, 0, 3'd4, "R1 reset state");
    // power-on delay is long in an RC mode
    measure(0, 3'd4, LONG_T, "R2 por intrc");
    measure(1, 3'd4, SHORT_T, "R3 clr intrc");
    measure(1, 3'd3, SHORT_T, "R3 clr ec");
    measure(1, 3'd5, SHORT_T, "R3 clr extrc");
    measure(2, 3'd4, SHORT_T, "R6 wdt intrc");
    measure(3, 3'd5, SHORT_T, "R7 pin extrc");
    measure(1, 3'd0, LONG_T, "R4 clr lp");
    measure(1, 3'd1, LONG_T, "R4 clr xt");
    measure(2, 3'd2, LONG_T, "R4 wdt hs");
    measure(3, 3'd6, LONG_T, "R4 pin reserved6");
    measure(1, 3'd7, LONG_T, "R4 clr reserved7");
    // clear pin held: stays in reset, counts only after release
    for (int i = 0; i < 30; i++) step(0, 1, 0, 0, 3'd1, "R5 clr held");
    measure(1, 3'd1, LONG_T, "R5 after release");
    // restart mid-count keeps no partial count
    step(0, 1, 0, 0, 3'd2, "R8 first event");
    idle(6, 3'd2, "R8 mid count");
    measure(2, 3'd2, LONG_T, "R8 restart mid");
    // por in RC mode interrupted before completion: still long
    step(1, 0, 0, 0, 3'd4, "R1 por again");
    idle(5, 3'd4, "R9 partial por delay");
    measure(1, 3'd4, LONG_T, "R9 interrupted por");
    measure(3, 3'd4, SHORT_T, "R9 flag now set");
    // released output stays low
    idle(20, 3'd4, "R10 stays low");
    check(core_rst == 1'b0, "R10 released", int'(core_rst), 0);
    // random run against the bench model
    rmode = 3'd4;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 199));
      if (r == 0) rmode = 3'($urandom_range(0, 7));
      step(r == 1, (r >= 2 && r <= 5), r == 6, r == 7, rmode, "R10 random");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule